// File: doc/BRIEF.md
# SIMD Saturating Narrowing Shift Unit

This datapath turns a 128-bit vector of double-width lanes into half-width lanes. Each source lane is shifted right by an immediate amount, optionally with round-to-nearest, and then reduced to half its width. The reduction either keeps the low bits or clamps the value into the range of the result type. Three clamping conversions are offered: signed to signed, signed to unsigned, and unsigned to unsigned.

The narrowed lanes fill one 64-bit half of the destination. In the low-half form the upper 64 bits are cleared. In the high-half form the old destination's low 64 bits are kept. A scalar form converts only lane 0 and zeroes every other bit.

An operation is presented for one cycle with `op_valid`. Its result is registered and appears on the next cycle. A sticky flag records every clamp until it is cleared explicitly. Instruction decode and the register file sit outside this block.

Top module: `narrow_shift_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0 and `sat_flag` and `res_vld` become 0 after that edge.
- R2: An operation accepted with `op_valid` at an edge drives `res_vld` high and `result` to its value after that edge. Without `op_valid`, `result` holds and `res_vld` is 0.
- R3: `size_code` 0, 1 and 2 select output lanes of 8, 16 and 32 bits, with 8, 4 and 2 lanes. Source lane i occupies `src_vec` bits starting at i*2w, and output lane i occupies narrowed bits starting at i*w. Code 3 is reserved.
- R4: `shamt` lies in 1..w. With `rnd_en`, 2^(shamt-1) is added before the shift, at full precision; a 64-bit source uses a 65-bit sum. The shift is arithmetic for modes 1 and 2 and logical for modes 0 and 3.
- R5: Mode 0 (truncate) treats the source as unsigned, keeps the low w bits of the shifted value and never clamps.
- R6: Mode 1 (signed to signed) clamps to the range -2^(w-1) to 2^(w-1)-1.
- R7: Mode 2 (signed to unsigned) clamps negative values to 0 and values above 2^w-1 to all ones.
- R8: Mode 3 (unsigned to unsigned) clamps values above 2^w-1 to all ones.
- R9: With `upper_sel`=0 and `scalar_en`=0, the narrowed lanes fill `result[63:0]` and `result[127:64]` is 0.
- R10: With `upper_sel`=1 and `scalar_en`=0, the narrowed lanes fill `result[127:64]` and `result[63:0]` equals `dst_old[63:0]`.
- R11: With `scalar_en`=1, only lane 0 is produced, in `result[w-1:0]`, and all other bits are 0. `upper_sel` has no effect, and only lane 0 can clamp.
- R12: `sat_flag` is set after any accepted operation in which a lane clamps. It stays set until a cycle with `sat_clr`=1 and no new clamp. When a clear and a clamp fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Accept an operation this cycle |
| src_vec | input | 128 | Double-width source lanes |
| dst_old | input | 128 | Previous destination value |
| size_code | input | 2 | Output lane size: 0=8, 1=16, 2=32 bits |
| shamt | input | 7 | Right shift amount, 1..w |
| rnd_en | input | 1 | Add rounding constant before shift |
| mode | input | 2 | 0 truncate, 1 s->s, 2 s->u, 3 u->u |
| upper_sel | input | 1 | Write the high half and keep the old low half |
| scalar_en | input | 1 | Produce only lane 0 |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| res_vld | output | 1 | Result updated on this cycle |
| result | output | 128 | Registered destination value |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The sticky flag's clear and a new clamp can arrive in the same cycle. The bench provokes this directly: it issues a saturating operation together with `sat_clr`, then a clear on its own. It judges the flag in the following cycles against a behavioural model that lets a set win over a clear. The high-half write is also checked with each new result, since it combines the fresh narrowed lanes with the `dst_old` low half presented in that same cycle. The checks also cover the 64-bit rounding carry, where truncation yields 0 but unsigned saturation yields all ones.

// File: rtl/nsu_pkg.sv
// Shared types for the narrowing shift unit.
package nsu_pkg;
    // Narrowing conversion selected per operation.
    typedef enum logic [1:0] {
        NSU_TRUNC  = 2'd0,
        NSU_SAT_SS = 2'd1,
        NSU_SAT_SU = 2'd2,
        NSU_SAT_UU = 2'd3
    } nsu_mode_e;
endpackage

// File: rtl/nsu_lane.sv
// One narrowing lane: extends, rounds, shifts right, then truncates or clamps
// to SRC_W/2 bits. Assumes shamt is in 1..SRC_W/2. Purely combinational.
module nsu_lane
    import nsu_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   src_lane,
    input  logic [6:0]         shamt,
    input  logic               rnd_en,
    input  nsu_mode_e          mode,
    output logic [SRC_W/2-1:0] narrowed,
    output logic               clamped
);
    localparam int OUT_W = SRC_W / 2;
    localparam int IW    = SRC_W + 2;

    logic              signed_src;
    logic signed [IW-1:0] ext, sum, shf;
    logic [IW-1:0]     rc;
    logic              fits_s, fits_u;

    // Extend, add rounding constant and shift with headroom for the carry.
    always_comb begin
        signed_src = (mode == NSU_SAT_SS) || (mode == NSU_SAT_SU);
        ext = signed_src ? {{2{src_lane[SRC_W-1]}}, src_lane} : {2'b00, src_lane};
        rc  = rnd_en ? ({{(IW-1){1'b0}}, 1'b1} << (shamt - 7'd1)) : '0;
        sum = ext + $signed(rc);
        shf = sum >>> shamt;
        fits_s = (&shf[IW-1:OUT_W-1]) || ~(|shf[IW-1:OUT_W-1]);
        fits_u = ~(|shf[IW-1:OUT_W]);
    end

    // Select truncation or the clamp for the requested conversion.
    always_comb begin
        narrowed = shf[OUT_W-1:0];
        clamped  = 1'b0;
        unique case (mode)
            NSU_TRUNC: ;
            NSU_SAT_SS: if (!fits_s) begin
                clamped  = 1'b1;
                narrowed = shf[IW-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
            end
            NSU_SAT_SU: if (shf[IW-1]) begin
                clamped  = 1'b1;
                narrowed = '0;
            end else if (!fits_u) begin
                clamped  = 1'b1;
                narrowed = '1;
            end
            NSU_SAT_UU: if (!fits_u) begin
                clamped  = 1'b1;
                narrowed = '1;
            end
            default: ;
        endcase
    end

    // Guard the conversion rules that the output values must obey.
    always_comb begin
        if (mode == NSU_TRUNC)
            a_r5_trunc_never_clamps: assert (!clamped);
        if (mode == NSU_SAT_UU && clamped)
            a_r8_uu_clamp_all_ones: assert (&narrowed);
        if (mode == NSU_SAT_SU && clamped)
            a_r7_su_clamp_edge: assert ((&narrowed) || ~(|narrowed));
    end
endmodule

// File: rtl/nsu_narrow.sv
// Builds the lanes for every size code, picks the requested size and applies
// the scalar mask. Assumes size_code < 3 when the output is used.
module nsu_narrow
    import nsu_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic [2*HALF_W-1:0] src_vec,
    input  logic [1:0]          size_code,
    input  logic [6:0]          shamt,
    input  logic                rnd_en,
    input  nsu_mode_e           mode,
    input  logic                scalar_en,
    output logic [HALF_W-1:0]   narrowed,
    output logic                any_clamp
);
    localparam int NUM_SIZES = 3;

    logic [NUM_SIZES-1:0][HALF_W-1:0] nar_by_size;
    logic [NUM_SIZES-1:0]             clamp_by_size;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int OUT_W = 8 << s;
        localparam int SRC_W = 2 * OUT_W;
        localparam int NL    = HALF_W / OUT_W;
        logic [HALF_W-1:0] nar_s;
        logic [NL-1:0]     clamp_s;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            nsu_lane #(.SRC_W(SRC_W)) u_lane (
                .src_lane (src_vec[l*SRC_W +: SRC_W]),
                .shamt    (shamt),
                .rnd_en   (rnd_en),
                .mode     (mode),
                .narrowed (nar_s[l*OUT_W +: OUT_W]),
                .clamped  (clamp_s[l])
            );
        end
        if (OUT_W < HALF_W) begin : g_mask
            assign nar_by_size[s] = scalar_en ? {{(HALF_W-OUT_W){1'b0}}, nar_s[OUT_W-1:0]} : nar_s;
        end else begin : g_nomask
            assign nar_by_size[s] = nar_s;
        end
        assign clamp_by_size[s] = scalar_en ? clamp_s[0] : |clamp_s;
    end

    // Pick the lane group matching the size code; the reserved code yields zero.
    always_comb begin
        narrowed  = '0;
        any_clamp = 1'b0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (size_code == 2'(s)) begin
                narrowed  = nar_by_size[s];
                any_clamp = clamp_by_size[s];
            end
        end
    end
endmodule

// File: rtl/narrow_shift_unit.sv
// Top: narrowing shift with half placement, registered result and a sticky
// clamp flag. One-cycle latency; synchronous active-low reset.
module narrow_shift_unit
    import nsu_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_old,
    input  logic [1:0]       size_code,
    input  logic [6:0]       shamt,
    input  logic             rnd_en,
    input  logic [1:0]       mode,
    input  logic             upper_sel,
    input  logic             scalar_en,
    input  logic             sat_clr,
    output logic             res_vld,
    output logic [VEC_W-1:0] result,
    output logic             sat_flag
);
    localparam int HALF_W = VEC_W / 2;

    nsu_mode_e         mode_e;
    logic [HALF_W-1:0] narrowed;
    logic              any_clamp;
    logic [VEC_W-1:0]  next_res;
    logic              unused_hi_dst;

    assign mode_e        = nsu_mode_e'(mode);
    assign unused_hi_dst = ^dst_old[VEC_W-1:HALF_W];

    nsu_narrow #(.HALF_W(HALF_W)) u_narrow (
        .src_vec   (src_vec),
        .size_code (size_code),
        .shamt     (shamt),
        .rnd_en    (rnd_en),
        .mode      (mode_e),
        .scalar_en (scalar_en),
        .narrowed  (narrowed),
        .any_clamp (any_clamp)
    );

    // Place the narrowed half: high half keeps old low half, otherwise clear top.
    always_comb begin
        if (upper_sel && !scalar_en) next_res = {narrowed, dst_old[HALF_W-1:0]};
        else                         next_res = {{HALF_W{1'b0}}, narrowed};
    end

    // Register the result and update the sticky flag (a new clamp beats a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            res_vld  <= 1'b0;
            sat_flag <= 1'b0;
        end else begin
            res_vld  <= op_valid;
            if (op_valid) result <= next_res;
            sat_flag <= (sat_flag & ~sat_clr) | (op_valid & any_clamp);
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !sat_flag && !res_vld));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_vld);
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_vld && $stable(result)));
    a_r9_low_form_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !upper_sel) |=> result[VEC_W-1:HALF_W] == '0);
    a_r10_high_form_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && upper_sel && !scalar_en) |=> result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]));
    a_r12_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);
    a_r12_rise_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(op_valid));
endmodule

// File: tb/narrow_shift_unit_tb.sv
module narrow_shift_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [127:0] src_vec = '0, dst_old = '0;
    logic [1:0]   size_code = '0;
    logic [6:0]   shamt = 7'd1;
    logic         rnd_en = 1'b0;
    logic [1:0]   mode = '0;
    logic         upper_sel = 1'b0, scalar_en = 1'b0, sat_clr = 1'b0;
    logic         res_vld, sat_flag;
    logic [127:0] result;

    int    n_checks = 0, n_fail = 0;
    string tag = "R1 reset";
    bit    done = 0;

    logic [127:0] exp_res = '0;
    logic         exp_vld = 1'b0, exp_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    narrow_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_vec(src_vec),
        .dst_old(dst_old), .size_code(size_code), .shamt(shamt), .rnd_en(rnd_en),
        .mode(mode), .upper_sel(upper_sel), .scalar_en(scalar_en), .sat_clr(sat_clr),
        .res_vld(res_vld), .result(result), .sat_flag(sat_flag)
    );

    // Behavioural reference for one operation, written from the requirements.
    function automatic void ref_op(input logic [127:0] src, input logic [127:0] dold,
                                   input int sz, input int sh, input bit rnd, input int md,
                                   input bit up, input bit sc,
                                   output logic [127:0] res, output bit sat);
        int w  = 8 << sz;
        int nl = sc ? 1 : 64 / w;
        logic [63:0] narrow = '0;
        sat = 0;
        for (int l = 0; l < nl; l++) begin
            logic signed [67:0] v, maxs, mins, maxu, o;
            logic [63:0] raw;
            raw = 64'(src >> (l * 2 * w));
            if (2 * w < 64) raw = raw & ((64'd1 << (2 * w)) - 64'd1);
            v = $signed({4'b0, raw});
            if ((md == 1 || md == 2) && raw[2*w-1]) v = v - (68'sd1 <<< (2 * w));
            if (rnd) v = v + (68'sd1 <<< (sh - 1));
            v = v >>> sh;
            maxs = (68'sd1 <<< (w - 1)) - 68'sd1;
            mins = -(68'sd1 <<< (w - 1));
            maxu = (68'sd1 <<< w) - 68'sd1;
            o = v & maxu;
            case (md)
                1: if (v > maxs) begin o = maxs; sat = 1; end
                   else if (v < mins) begin o = mins & maxu; sat = 1; end
                2: if (v < 0) begin o = 0; sat = 1; end
                   else if (v > maxu) begin o = maxu; sat = 1; end
                3: if (v > maxu) begin o = maxu; sat = 1; end
                default: ;
            endcase
            narrow = narrow | (64'(o) << (l * w));
        end
        if (sc || !up) res = {64'b0, narrow};
        else           res = {narrow, dold[63:0]};
    endfunction

    // Cycle model updated on every edge from the same inputs.
    always @(posedge clk) begin
        logic [127:0] r;
        bit s;
        if (!rst_n) begin
            exp_res  <= '0;
            exp_vld  <= 1'b0;
            exp_flag <= 1'b0;
        end else begin
            ref_op(src_vec, dst_old, int'(size_code), int'(shamt), rnd_en, int'(mode),
                   upper_sel, scalar_en, r, s);
            exp_vld <= op_valid;
            if (op_valid) exp_res <= r;
            exp_flag <= (exp_flag & ~sat_clr) | (op_valid & s);
        end
    end

    // Compare away from the active edge on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (result !== exp_res || res_vld !== exp_vld || sat_flag !== exp_flag) begin
                n_fail++;
                $display("FAIL %s: result=%h vld=%0b flag=%0b expected result=%h vld=%0b flag=%0b",
                         tag, result, res_vld, sat_flag, exp_res, exp_vld, exp_flag);
            end
        end
    end

    task automatic op(input int sz, input int sh, input bit rnd, input int md, input bit up,
                      input bit sc, input bit clr, input logic [127:0] src, input logic [127:0] dold);
        @(negedge clk);
        op_valid = 1'b1; size_code = 2'(sz); shamt = 7'(sh); rnd_en = rnd; mode = 2'(md);
        upper_sel = up; scalar_en = sc; sat_clr = clr; src_vec = src; dst_old = dold;
    endtask

    task automatic idle(input bit clr);
        @(negedge clk);
        op_valid = 1'b0; sat_clr = clr;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_fail++; n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tag = "R1 reset";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(0);
        tag = "R2 idle hold";
        idle(0); idle(0);

        tag = "R5 truncate rounding carry 64-bit";
        op(2, 32, 1, 0, 0, 0, 0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, '0);
        idle(0);
        tag = "R8 unsigned clamp 65-bit rounding";
        op(2, 32, 1, 3, 0, 0, 0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, '0);
        idle(0);
        tag = "R12 clear with new clamp same cycle";
        op(0, 1, 0, 3, 0, 0, 1, {8{16'hFFFF}}, '0);
        idle(0);
        tag = "R12 clear alone";
        idle(1); idle(0);
        tag = "R6 signed clamp max and min";
        op(0, 1, 0, 1, 0, 0, 0, {{6{16'h0010}}, 16'h8000, 16'h7FFF}, '0);
        idle(1);
        tag = "R7 signed to unsigned negative";
        op(1, 4, 1, 2, 0, 0, 0, {32'h0000_0100, 32'h7FFF_FFFF, 32'h0001_0000, 32'hFFFF_0000}, '0);
        idle(1);
        tag = "R4 rounding arithmetic shift";
        op(1, 16, 1, 1, 0, 0, 0, {32'hFFFF_8000, 32'hFFFF_7FFF, 32'h0000_8000, 32'h0000_7FFF}, '0);
        idle(1);
        tag = "R10 high half keeps old low";
        op(0, 3, 0, 0, 1, 0, 0, {8{16'h1234}}, {64'hDEAD_BEEF_0000_1111, 64'hCAFE_F00D_5555_AAAA});
        idle(0);
        tag = "R11 scalar ignores upper select";
        op(1, 2, 0, 3, 1, 1, 0, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0040}, {128{1'b1}});
        idle(0);
        tag = "R9 low half form";
        op(2, 8, 0, 0, 0, 0, 0, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, {128{1'b1}});
        idle(0);

        tag = "R3 random lane layout all modes";
        for (int i = 0; i < 4000; i++) begin
            int sz = $urandom_range(2, 0);
            int w = 8 << sz;
            logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
            if (($urandom % 4) == 0) s = s >> ($urandom % 128);
            @(negedge clk);
            op_valid = ($urandom % 4) != 0;
            sat_clr = ($urandom % 4) == 0;
            size_code = 2'(sz);
            shamt = 7'($urandom_range(w, 1));
            rnd_en = $urandom % 2;
            mode = 2'($urandom % 4);
            upper_sel = $urandom % 2;
            scalar_en = ($urandom % 5) == 0;
            src_vec = s;
            dst_old = {$urandom, $urandom, $urandom, $urandom};
        end
        idle(0); idle(0);

        tag = "R1 reset mid-run";
        @(negedge clk); rst_n = 1'b0;
        idle(0); idle(0);
        rst_n = 1'b1;
        idle(0); idle(0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule